// File: doc/BRIEF.md
# Shared Memory Window Bus Bridge

This block is the slave-side bridge that lets a master on an external, asynchronous system bus reach a local shared DRAM. The external master drives active-low address and data strobes, an address, write data, a direction bit and a read-modify-write indicator. The bridge passes both strobes through a synchronizer. It then tests the address page against a programmable inclusive window of 4 KB pages. On a hit it asks the local processor for the local bus. Once the bus is granted, it runs one memory cycle and answers the external master with an acknowledge or a bus error.

In early-release mode the local bus is handed back as soon as the memory cycle finishes, and the external handshake completes on its own afterwards. In hold mode the bus stays owned until the external master removes its address strobe. A read-modify-write keeps the bus across both of its data phases in either mode, so the pair cannot be split by another local master. Writes into a protected window never reach memory and end with a bus error.

Top module: `shmwin_bridge`

## Requirements
- R1: After reset, lb_req, mem_stb, ext_ack and ext_berr are all 0.
- R2: An access hits when win_lo <= ext_addr[31:12] <= win_hi, with both bounds inclusive. When win_lo > win_hi, no address hits. A miss produces no ext_ack, no ext_berr, no lb_req and no memory cycle.
- R3: mem_stb is asserted only while lb_req and lb_gnt are both high, and on a hit lb_req rises before any memory cycle starts.
- R4: A read returns on ext_rdata the memory word at the address, valid while ext_ack is high. A write stores ext_wdata at the address. ext_ack and ext_berr are never high together.
- R5: When cfg_wprot is 1, a write to the window is answered with ext_berr, makes no memory write and does not request the local bus.
- R6: With early release selected, a plain (non read-modify-write) access has lb_req low in the cycle in which ext_ack rises.
- R7: With early release off, lb_req stays high from the grant until the address strobe is removed. It then falls within 6 cycles.
- R8: When ext_rmw is 1 at the start of a cycle, lb_req stays high through the read phase, the gap between data strobes and the write phase, whatever the early-release setting.
- R9: ext_ack and ext_berr fall within 4 clock cycles after ext_ds_n goes high (two synchronizer stages plus one state update).
- R10: cfg_early is sampled only when an external cycle starts. A change during a cycle does not alter that cycle's release behaviour. The sampled copy resets to early release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_win_lo | input | ADDR_W-PAGE_SHIFT | First page of the window |
| cfg_win_hi | input | ADDR_W-PAGE_SHIFT | Last page of the window |
| cfg_wprot | input | 1 | Window is write protected |
| cfg_early | input | 1 | 1 = release local bus when memory cycle ends |
| ext_as_n | input | 1 | External address strobe, asynchronous, active low |
| ext_ds_n | input | 1 | External data strobe, asynchronous, active low |
| ext_wr | input | 1 | 1 = write phase |
| ext_rmw | input | 1 | Cycle is a read-modify-write pair |
| ext_addr | input | ADDR_W | External byte address |
| ext_wdata | input | DATA_W | External write data |
| ext_rdata | output | DATA_W | Read data returned to the external master |
| ext_ack | output | 1 | Data phase completed |
| ext_berr | output | 1 | Data phase refused (protected write) |
| lb_req | output | 1 | Local bus mastership request |
| lb_gnt | input | 1 | Local bus grant |
| mem_stb | output | 1 | Memory cycle strobe |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_done | input | 1 | Memory cycle finished, read data valid |

## Verification
A wrong internal state usually shows as an ownership error on lb_req. Examples are a bus kept after an early-release access, a request dropped in the gap of a read-modify-write pair, or a memory strobe outside a grant. These show in the same cycle ext_ack rises or during the strobe gap, a few cycles after the strobe edge. Decode or protection faults show at the external port: an acknowledge arrives where none should, or is missing. Or a word read back through the bridge differs from the bench's shadow copy at the next read of that address. A stuck handshake shows as an acknowledge that outlives the data strobe by more than four cycles.

// File: rtl/shmwin_pkg.sv
package shmwin_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,   // waiting for a strobed access
      ST_REQ,    // bus requested, waiting for grant
      ST_MEM,    // memory cycle running
      ST_ACK,    // acknowledge held until data strobe removed
      ST_BERR,   // bus error held until data strobe removed
      ST_GAP,    // between data phases, address strobe still held
      ST_SKIP    // address missed the window
   } bstate_e;
endpackage

// File: rtl/shmwin_sync.sv
module shmwin_sync #(
   parameter int        STAGES    = 2,
   parameter int        W         = 1,
   parameter logic      RESET_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("shmwin_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain[s] <= {W{RESET_VAL}};
         else if (s == 0) chain[s] <= d_async;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/shmwin_decode.sv
module shmwin_decode #(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 12,
   localparam int PAGE_W    = ADDR_W - PAGE_SHIFT
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [PAGE_W-1:0] win_lo,
   input  logic [PAGE_W-1:0] win_hi,
   output logic              hit
);
   if (PAGE_W < 1) begin : g_bad_page
      $error("shmwin_decode: PAGE_SHIFT must be below ADDR_W");
   end

   logic [PAGE_W-1:0] page;
   logic              enabled;
   logic              above_lo;
   logic              below_hi;

   assign page     = addr[ADDR_W-1:PAGE_SHIFT];
   assign enabled  = (win_lo <= win_hi);
   assign above_lo = (page >= win_lo);
   assign below_hi = (page <= win_hi);
   assign hit      = enabled && above_lo && below_hi;
endmodule

// File: rtl/shmwin_seq.sv
module shmwin_seq
   import shmwin_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              as_s,
   input  logic              ds_s,
   input  logic              hit,
   input  logic              cfg_wprot,
   input  logic              cfg_early,
   input  logic              ext_wr,
   input  logic              ext_rmw,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic [DATA_W-1:0] ext_wdata,
   output logic [DATA_W-1:0] ext_rdata,
   output logic              ext_ack,
   output logic              ext_berr,
   output logic              lb_req,
   input  logic              lb_gnt,
   output logic              mem_stb,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_done
);
   bstate_e           state_q;
   logic              own_q;
   logic              early_q;
   logic              rmw_q;
   logic              wr_q;
   logic              ack_q;
   logic              berr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              refuse;

   // a phase is refused when it writes into a protected window
   assign refuse = ext_wr && cfg_wprot;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         own_q   <= 1'b0;
         early_q <= 1'b1;
         rmw_q   <= 1'b0;
         wr_q    <= 1'b0;
         ack_q   <= 1'b0;
         berr_q  <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (as_s && ds_s) begin
                  early_q <= cfg_early;
                  rmw_q   <= ext_rmw;
                  wr_q    <= ext_wr;
                  addr_q  <= ext_addr;
                  wdata_q <= ext_wdata;
                  if (!hit) begin
                     state_q <= ST_SKIP;
                  end else if (refuse) begin
                     berr_q  <= 1'b1;
                     state_q <= ST_BERR;
                  end else begin
                     own_q   <= 1'b1;
                     state_q <= ST_REQ;
                  end
               end
            end
            ST_REQ: begin
               if (lb_gnt) state_q <= ST_MEM;
            end
            ST_MEM: begin
               if (mem_done) begin
                  if (!wr_q) rdata_q <= mem_rdata;
                  ack_q   <= 1'b1;
                  state_q <= ST_ACK;
                  if (early_q && !rmw_q) own_q <= 1'b0;
               end
            end
            ST_ACK: begin
               if (!ds_s) begin
                  ack_q   <= 1'b0;
                  state_q <= ST_GAP;
               end
            end
            ST_BERR: begin
               if (!ds_s) begin
                  berr_q  <= 1'b0;
                  state_q <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (!as_s) begin
                  own_q   <= 1'b0;
                  state_q <= ST_IDLE;
               end else if (rmw_q && ds_s) begin
                  wr_q    <= ext_wr;
                  addr_q  <= ext_addr;
                  wdata_q <= ext_wdata;
                  if (refuse) begin
                     berr_q  <= 1'b1;
                     state_q <= ST_BERR;
                  end else if (own_q) begin
                     state_q <= ST_MEM;
                  end else begin
                     own_q   <= 1'b1;
                     state_q <= ST_REQ;
                  end
               end
            end
            ST_SKIP: begin
               if (!as_s) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign lb_req    = own_q;
   assign mem_stb   = (state_q == ST_MEM);
   assign mem_we    = wr_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign ext_ack   = ack_q;
   assign ext_berr  = berr_q;
   assign ext_rdata = rdata_q;

   // R3: memory is touched only under an owned and granted bus
   p_strobe_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_stb |-> (lb_req && lb_gnt));

   // R4: the two terminations exclude each other
   p_single_term_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(ext_ack && ext_berr));

   // R5: a refused phase never overlaps a memory cycle
   p_berr_no_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ext_berr |-> !mem_stb);

   // R6: early release hands the bus back by the time the ack appears
   p_early_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ext_ack) && early_q && !rmw_q) |-> !lb_req);

   // R7: hold mode keeps the bus while the address strobe is present
   p_hold_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lb_req && !early_q && as_s) |=> lb_req);

   // R8: a read-modify-write pair is never split
   p_rmw_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lb_req && rmw_q && as_s) |=> lb_req);

   // R9: the ack follows the data strobe down
   p_ack_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_ack && !ds_s) |=> !ext_ack);

   // R9: the bus error follows the data strobe down
   p_berr_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_berr && !ds_s) |=> !ext_berr);
endmodule

// File: rtl/shmwin_bridge.sv
module shmwin_bridge
   import shmwin_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int PAGE_SHIFT  = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-PAGE_SHIFT-1:0] cfg_win_lo,
   input  logic [ADDR_W-PAGE_SHIFT-1:0] cfg_win_hi,
   input  logic                         cfg_wprot,
   input  logic                         cfg_early,
   input  logic                         ext_as_n,
   input  logic                         ext_ds_n,
   input  logic                         ext_wr,
   input  logic                         ext_rmw,
   input  logic [ADDR_W-1:0]            ext_addr,
   input  logic [DATA_W-1:0]            ext_wdata,
   output logic [DATA_W-1:0]            ext_rdata,
   output logic                         ext_ack,
   output logic                         ext_berr,
   output logic                         lb_req,
   input  logic                         lb_gnt,
   output logic                         mem_stb,
   output logic                         mem_we,
   output logic [ADDR_W-1:0]            mem_addr,
   output logic [DATA_W-1:0]            mem_wdata,
   input  logic [DATA_W-1:0]            mem_rdata,
   input  logic                         mem_done
);
   localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

   if (DATA_W < 8) begin : g_bad_data
      $error("shmwin_bridge: DATA_W must be at least 8");
   end

   logic [1:0] strobes_n;
   logic       as_s;
   logic       ds_s;
   logic       hit;

   shmwin_sync #(
      .STAGES    (SYNC_STAGES),
      .W         (2),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({ext_as_n, ext_ds_n}),
      .q_sync  (strobes_n)
   );

   assign as_s = ~strobes_n[1];
   assign ds_s = ~strobes_n[0];

   shmwin_decode #(
      .ADDR_W     (ADDR_W),
      .PAGE_SHIFT (PAGE_SHIFT)
   ) u_decode (
      .addr   (ext_addr),
      .win_lo (cfg_win_lo[PAGE_W-1:0]),
      .win_hi (cfg_win_hi[PAGE_W-1:0]),
      .hit    (hit)
   );

   shmwin_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .as_s      (as_s),
      .ds_s      (ds_s),
      .hit       (hit),
      .cfg_wprot (cfg_wprot),
      .cfg_early (cfg_early),
      .ext_wr    (ext_wr),
      .ext_rmw   (ext_rmw),
      .ext_addr  (ext_addr),
      .ext_wdata (ext_wdata),
      .ext_rdata (ext_rdata),
      .ext_ack   (ext_ack),
      .ext_berr  (ext_berr),
      .lb_req    (lb_req),
      .lb_gnt    (lb_gnt),
      .mem_stb   (mem_stb),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_done  (mem_done)
   );

   // R2: without a request there is never a memory cycle
   p_no_req_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lb_req |-> !mem_stb);

   // R1: outputs quiet in the first cycle after reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!lb_req && !ext_ack && !ext_berr && !mem_stb));
endmodule

// File: tb/shmwin_bridge_bench.sv
module shmwin_bridge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] cfg_win_lo = 20'h00010;
   logic [19:0] cfg_win_hi = 20'h00013;
   logic        cfg_wprot = 1'b0;
   logic        cfg_early = 1'b1;
   logic        ext_as_n = 1'b1;
   logic        ext_ds_n = 1'b1;
   logic        ext_wr = 1'b0;
   logic        ext_rmw = 1'b0;
   logic [31:0] ext_addr = '0;
   logic [31:0] ext_wdata = '0;
   logic [31:0] ext_rdata;
   logic        ext_ack, ext_berr, lb_req, mem_stb, mem_we;
   logic        lb_gnt = 1'b0;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_done = 1'b0;

   int total = 0;
   int bad = 0;
   int wr_cnt = 0;
   int gnt_viol = 0;
   int req_seen = 0;
   logic [31:0] dram   [64];
   logic [31:0] shadow [64];

   always #4 clk = ~clk;

   shmwin_bridge u_shmwin_bridge (
      .clk(clk), .rst_n(rst_n), .cfg_win_lo(cfg_win_lo), .cfg_win_hi(cfg_win_hi),
      .cfg_wprot(cfg_wprot), .cfg_early(cfg_early), .ext_as_n(ext_as_n),
      .ext_ds_n(ext_ds_n), .ext_wr(ext_wr), .ext_rmw(ext_rmw), .ext_addr(ext_addr),
      .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ack(ext_ack),
      .ext_berr(ext_berr), .lb_req(lb_req), .lb_gnt(lb_gnt), .mem_stb(mem_stb),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_done(mem_done)
   );

   // local arbiter and memory model
   always @(posedge clk) begin
      if (!rst_n) begin
         lb_gnt   <= 1'b0;
         mem_done <= 1'b0;
      end else begin
         lb_gnt   <= lb_req;
         mem_done <= mem_stb && !mem_done;
         if (mem_stb && !mem_done) begin
            if (mem_we) begin
               dram[mem_addr[7:2]] <= mem_wdata;
               wr_cnt <= wr_cnt + 1;
            end
            mem_rdata <= dram[mem_addr[7:2]];
         end
         if (mem_stb && !(lb_gnt && lb_req)) gnt_viol <= gnt_viol + 1;
         if (lb_req) req_seen <= req_seen + 1;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic bit exp_hit(input logic [31:0] a);
      return (cfg_win_lo <= cfg_win_hi) && (a[31:12] >= cfg_win_lo)
             && (a[31:12] <= cfg_win_hi);
   endfunction

   logic        r_ack, r_berr, r_req, r_req_mid, r_req_end;
   logic [31:0] r_data;
   int          r_drop;

   task automatic access(input logic [31:0] a, input logic w, input logic [31:0] d,
                         input bit flip);
      bit got = 0;
      ext_addr = a; ext_wr = w; ext_wdata = d; ext_rmw = 1'b0;
      @(negedge clk);
      ext_as_n = 1'b0; ext_ds_n = 1'b0;
      for (int i = 0; i < 30 && !got; i++) begin
         @(negedge clk);
         if (flip && i == 3) cfg_early = ~cfg_early;
         if (ext_ack || ext_berr) got = 1;
      end
      r_ack = ext_ack; r_berr = ext_berr; r_data = ext_rdata; r_req = lb_req;
      ext_ds_n = 1'b1;
      r_drop = 0;
      for (int i = 0; i < 20 && (ext_ack || ext_berr); i++) begin
         @(negedge clk);
         r_drop++;
      end
      repeat (2) @(negedge clk);
      r_req_mid = lb_req;
      ext_as_n = 1'b1;
      repeat (6) @(negedge clk);
      r_req_end = lb_req;
   endtask

   task automatic check_access(input logic [31:0] a, input logic w, input logic [31:0] d,
                               input string tag);
      bit hit = exp_hit(a);
      bit refuse = hit && w && cfg_wprot;
      bit early = cfg_early;
      int wc0 = wr_cnt;
      access(a, w, d, 1'b0);
      if (!hit) begin
         chk(!r_ack && !r_berr, {tag, " R2 miss no response"}, {30'b0, r_ack, r_berr}, 0);
         chk(r_req_mid == 1'b0, {tag, " R2 miss no bus request"}, r_req_mid, 0);
      end else if (refuse) begin
         chk(r_berr && !r_ack, {tag, " R5 protected write bus error"},
             {30'b0, r_ack, r_berr}, 1);
         chk(wr_cnt == wc0, {tag, " R5 no memory write"}, wr_cnt, wc0);
         chk(r_drop <= 4, {tag, " R9 berr drop"}, r_drop, 4);
      end else begin
         chk(r_ack && !r_berr, {tag, " R4 ack"}, {30'b0, r_ack, r_berr}, 2);
         if (!w) chk(r_data == shadow[a[7:2]], {tag, " R4 read data"}, r_data,
                     shadow[a[7:2]]);
         else shadow[a[7:2]] = d;
         if (early) chk(r_req == 1'b0, {tag, " R6 early release at ack"}, r_req, 0);
         else begin
            chk(r_req == 1'b1, {tag, " R7 hold at ack"}, r_req, 1);
            chk(r_req_mid == 1'b1, {tag, " R7 hold until AS removed"}, r_req_mid, 1);
         end
         chk(r_drop <= 4, {tag, " R9 ack drop"}, r_drop, 4);
      end
      chk(r_req_end == 1'b0, {tag, " R7 bus released after cycle"}, r_req_end, 0);
   endtask

   task automatic rmw_access(input logic [31:0] a, input logic [31:0] d, input string tag);
      bit got = 0;
      bit held = 1;
      logic [31:0] old;
      ext_addr = a; ext_wr = 1'b0; ext_rmw = 1'b1; ext_wdata = '0;
      @(negedge clk);
      ext_as_n = 1'b0; ext_ds_n = 1'b0;
      for (int i = 0; i < 30 && !got; i++) begin
         @(negedge clk);
         if (ext_ack) got = 1;
      end
      old = ext_rdata;
      chk(got, {tag, " R8 read phase ack"}, {31'b0, got}, 1);
      chk(old == shadow[a[7:2]], {tag, " R8 read phase data"}, old, shadow[a[7:2]]);
      ext_ds_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (!lb_req) held = 0;
      end
      ext_wr = 1'b1; ext_wdata = d; ext_ds_n = 1'b0;
      got = 0;
      for (int i = 0; i < 30 && !got; i++) begin
         @(negedge clk);
         if (!lb_req && !ext_ack) held = 0;
         if (ext_ack || ext_berr) got = 1;
      end
      chk(held, {tag, " R8 bus held across pair"}, {31'b0, held}, 1);
      chk(ext_ack, {tag, " R8 write phase ack"}, {31'b0, ext_ack}, 1);
      shadow[a[7:2]] = d;
      ext_ds_n = 1'b1;
      repeat (5) @(negedge clk);
      ext_as_n = 1'b1; ext_rmw = 1'b0; ext_wr = 1'b0;
      repeat (6) @(negedge clk);
      chk(!lb_req, {tag, " R8 released after pair"}, lb_req, 0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin
         dram[i] = '0;
         shadow[i] = '0;
      end
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk(!lb_req && !mem_stb && !ext_ack && !ext_berr, "R1 reset outputs",
          {28'b0, lb_req, mem_stb, ext_ack, ext_berr}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!lb_req && !mem_stb, "R1 idle after reset", {30'b0, lb_req, mem_stb}, 0);

      // directed: boundary pages, write then read back
      check_access(32'h0001_0004, 1'b1, 32'hCAFE_0001, "lo page wr");
      check_access(32'h0001_0004, 1'b0, '0, "lo page rd");
      check_access(32'h0001_3FF8, 1'b1, 32'h1234_5678, "hi page wr");
      check_access(32'h0001_3FF8, 1'b0, '0, "hi page rd");
      check_access(32'h0000_FFFC, 1'b0, '0, "below lo");
      check_access(32'h0001_4000, 1'b1, 32'hDEAD_BEEF, "above hi");
      chk(wr_cnt == 2, "R2 miss wrote nothing", wr_cnt, 2);
      check_access(32'h0001_0004, 1'b0, '0, "R2 value kept after miss");

      // protection
      cfg_wprot = 1'b1;
      check_access(32'h0001_0004, 1'b1, 32'hBAD0_BAD0, "prot wr");
      check_access(32'h0001_0004, 1'b0, '0, "prot rd");
      cfg_wprot = 1'b0;
      check_access(32'h0001_0004, 1'b0, '0, "R5 unchanged after refusal");

      // hold mode
      cfg_early = 1'b0;
      check_access(32'h0001_1010, 1'b1, 32'h0BAD_F00D, "hold wr");
      check_access(32'h0001_1010, 1'b0, '0, "hold rd");

      // R10: a change mid-cycle leaves that cycle in its sampled mode
      cfg_early = 1'b1;
      access(32'h0001_1010, 1'b0, '0, 1'b1);
      chk(r_ack && r_req == 1'b0, "R10 early kept despite change",
          {30'b0, r_ack, r_req}, 2);
      access(32'h0001_1010, 1'b0, '0, 1'b1);
      chk(r_ack && r_req == 1'b1, "R10 hold kept despite change",
          {30'b0, r_ack, r_req}, 3);
      cfg_early = 1'b1;

      // read-modify-write in both modes
      rmw_access(32'h0001_2020, 32'h5555_AAAA, "rmw early");
      cfg_early = 1'b0;
      rmw_access(32'h0001_2020, 32'hA5A5_5A5A, "rmw hold");
      cfg_early = 1'b1;
      check_access(32'h0001_2020, 1'b0, '0, "R8 rmw result");

      // disabled window
      cfg_win_lo = 20'h00020; cfg_win_hi = 20'h0001F;
      check_access(32'h0001_F000, 1'b0, '0, "R2 disabled");
      check_access(32'h0002_0000, 1'b1, 32'h1, "R2 disabled wr");
      cfg_win_lo = 20'h00010; cfg_win_hi = 20'h00013;

      // constrained random
      for (int n = 0; n < 60; n++) begin
         logic [19:0] pg;
         logic [31:0] a;
         case ($urandom % 6)
            0: pg = cfg_win_lo - 20'd1;
            1: pg = cfg_win_lo;
            2: pg = cfg_win_hi;
            3: pg = cfg_win_hi + 20'd1;
            default: pg = cfg_win_lo + 20'($urandom % 4);
         endcase
         a = {pg, 4'h0, 6'($urandom), 2'b00};
         cfg_wprot = (($urandom % 5) == 0);
         cfg_early = ($urandom % 2) != 0;
         check_access(a, ($urandom % 2) != 0, $urandom, "random");
      end
      cfg_wprot = 1'b0;

      chk(gnt_viol == 0, "R3 strobe only under grant", gnt_viol, 0);
      chk(req_seen > 0, "R3 bus requested on hits", req_seen, 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule